// File: doc/BRIEF.md
# Serial Command Register Slave

This block is a serial-bus slave that gives an external master read and write access to a small bank of 16-bit registers. Every transaction is one framed command. The master pulls the active-low select low. It then clocks in an 8-bit opcode, an 8-bit register address and one 16-bit data word, for 32 serial clocks. The master changes its data on the falling serial-clock edge, and the slave samples on the rising edge. Every field goes most significant bit first. A write command stores the data word in the addressed register. A read command returns the addressed register on the serial output during the data phase.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers and are edge-detected in the system-clock domain, so the serial clock must be several times slower than the system clock. After each completed read or write, the block raises `busy` for `HOLD_CYCLES` system clocks (5 µs at the default 250 MHz). Any frame whose select falls while `busy` is high is ignored.

The frame controller is a state machine with these states:
- ST_IDLE: select released.
- ST_OPC: receiving the opcode.
- ST_ADR: receiving the address.
- ST_WDAT: receiving write data.
- ST_RDAT: sending read data.
- ST_SKIP: discarding the rest of the frame.

Its transitions are:
- IDLE→OPC on select low while not busy.
- IDLE→SKIP on select low while busy.
- OPC→ADR on a valid opcode.
- OPC→SKIP on an unknown opcode.
- ADR→WDAT for a write.
- ADR→RDAT for a read.
- WDAT→SKIP and RDAT→SKIP after the 16th data bit.
- Any state→IDLE whenever select is high.

Top module: `cmdreg_slave`

## Requirements
- R1: After reset, `busy` is 0, `miso` is 0, and every register reads back as 0.
- R2: A frame with opcode 8'h02, an address below NUM_REGS and 16 data bits loads the data word into that register. Bits are sampled on rising `sck`, MSB first.
- R3: In a frame with opcode 8'h03, `miso` stays 0 up to the falling `sck` edge that follows the last address bit. From that edge on, it presents the addressed register MSB first, changing on falling edges, so that the master reads all 16 bits on the 16 data rising edges.
- R4: Only the addressed register changes. A write to an address of NUM_REGS or above changes no register, and a read of such an address returns 0.
- R5: An opcode other than 8'h02 or 8'h03 makes the rest of the frame ignored. `miso` stays 0, no register changes, and `busy` does not rise.
- R6: Raising `cs_n` before the 32nd bit abandons the frame. No register is written, `busy` does not rise, and the next frame decodes from its first bit.
- R7: A write changes the register only once all 16 data bits have arrived. A frame cut after 31 bits leaves the register as it was.
- R8: A completed read or write holds `busy` high for exactly HOLD_CYCLES consecutive system clocks.
- R9: A frame whose `cs_n` falls while `busy` is high is ignored. No register changes and `miso` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in, sampled on rising sck |
| miso | output | 1 | Serial data out, changes on falling sck |
| busy | output | 1 | High during the hold-off after a command |

## Verification
A write-then-read sweep covers every bit position of the data word across all registers, using patterns that differ per register. This separates bit-order faults, shift-alignment faults and address-decode faults. Out-of-range addresses, unknown opcodes, frames cut at 20 and 31 bits, and a frame started while busy are each followed by read-back of the affected register. This shows whether a stray write slipped through. The length of the busy pulse is counted in system clocks and compared with the parameter after both a write and a read. The `miso` level just before the first data falling edge shows whether read data starts one edge early.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int FW = 8;
    localparam logic [FW-1:0] OPC_RD = 8'h03;
    localparam logic [FW-1:0] OPC_WR = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } fstate_t;
endpackage

// File: rtl/cmdreg_sync.sv
module cmdreg_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/cmdreg_regfile.sv
module cmdreg_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [7:0]    wadr_i,
    input  logic [DW-1:0] wdat_i,
    input  logic [7:0]    radr_i,
    output logic [DW-1:0] rdat_o
);
    localparam int          IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0]  LIM   = 9'(NUM_REGS);

    logic [NUM_REGS*DW-1:0] regs_w;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (we_i && ({1'b0, wadr_i} == 9'(g))) begin
                r_q <= wdat_i;
            end
        end
        assign regs_w[g*DW +: DW] = r_q;
    end

    logic [IDX_W-1:0] ridx;
    assign ridx = radr_i[IDX_W-1:0];

    always_comb begin
        rdat_o = '0;
        if ({1'b0, radr_i} < LIM) begin
            rdat_o = regs_w[ridx*DW +: DW];
        end
    end

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_w));

    // R4
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ({1'b0, wadr_i} >= LIM)) |=> $stable(regs_w));
endmodule

// File: rtl/cmdreg_holdoff.sv
module cmdreg_holdoff #(
    parameter int HOLD_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    output logic busy_o
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (done_i) begin
            hold_q <= HW'(HOLD_CYCLES);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign busy_o = (hold_q != '0);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (busy_o && hold_q == HW'(HOLD_CYCLES)));

    // R8
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> (hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/cmdreg_fsm.sv
module cmdreg_fsm
    import cmdreg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic          busy_i,
    input  logic [DW-1:0] rdat_i,
    output logic [7:0]    radr_o,
    output logic          we_o,
    output logic [7:0]    wadr_o,
    output logic [DW-1:0] wdat_o,
    output logic          done_o,
    output logic          miso_o
);
    localparam int            CW       = $clog2(DW);
    localparam logic [CW-1:0] LAST_FLD = CW'(FW - 1);
    localparam logic [CW-1:0] LAST_DAT = CW'(DW - 1);

    fstate_t st_q, st_d;

    logic          sck_p;
    logic [CW-1:0] cnt_q;
    logic [DW-2:0] sh_q;
    logic [FW-1:0] op_q;
    logic [FW-1:0] adr_q;
    logic [DW-1:0] tx_q;
    logic          miso_q;

    logic          rise, fall;
    logic [FW-1:0] byte_in;
    logic [DW-1:0] word_in;
    logic          fld_end, dat_end;

    assign rise    = sck_s & ~sck_p;
    assign fall    = ~sck_s & sck_p;
    assign byte_in = {sh_q[FW-2:0], mosi_s};
    assign word_in = {sh_q, mosi_s};
    assign fld_end = rise && (cnt_q == LAST_FLD);
    assign dat_end = rise && (cnt_q == LAST_DAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!cs_n_s) st_d = busy_i ? ST_SKIP : ST_OPC;
            ST_OPC:  if (fld_end)
                         st_d = (byte_in == OPC_RD || byte_in == OPC_WR) ? ST_ADR : ST_SKIP;
            ST_ADR:  if (fld_end) st_d = (op_q == OPC_WR) ? ST_WDAT : ST_RDAT;
            ST_WDAT: if (dat_end) st_d = ST_SKIP;
            ST_RDAT: if (dat_end) st_d = ST_SKIP;
            ST_SKIP: st_d = ST_SKIP;
            default: st_d = ST_IDLE;
        endcase
        if (cs_n_s) st_d = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
            op_q   <= '0;
            adr_q  <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else begin
            sck_p <= sck_s;
            if (st_d != st_q) cnt_q <= '0;
            else if (rise)    cnt_q <= cnt_q + 1'b1;
            if (rise) sh_q <= word_in[DW-2:0];
            if (st_q == ST_OPC && fld_end) op_q <= byte_in;
            if (st_q == ST_ADR && fld_end) begin
                adr_q  <= byte_in;
                tx_q   <= rdat_i;
                miso_q <= 1'b0;
            end else if (st_q == ST_RDAT && fall) begin
                miso_q <= tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        radr_o = byte_in;
        wadr_o = adr_q;
        wdat_o = word_in;
        done_o = !cs_n_s && dat_end && (st_q == ST_WDAT || st_q == ST_RDAT);
        we_o   = done_o && (st_q == ST_WDAT);
        miso_o = (st_q == ST_RDAT) && miso_q;
    end

    // R6
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (st_q == ST_IDLE));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !cs_n_s && busy_i) |=> (st_q == ST_SKIP));

    // R2
    wr_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WDAT) |-> (op_q == OPC_WR));

    // R3
    rd_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RDAT) |-> (op_q == OPC_RD));

    // R5
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SKIP) |-> (!miso_o && !we_o));
endmodule

// File: rtl/cmdreg_slave.sv
module cmdreg_slave #(
    parameter int NUM_REGS    = 8,
    parameter int HOLD_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic busy
);
    localparam int DW = 16;

    logic          sck_s, cs_n_s, mosi_s;
    logic          we, done;
    logic [7:0]    radr, wadr;
    logic [DW-1:0] wdat, rdat;

    cmdreg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sck, cs_n, mosi}),
        .q       ({sck_s, cs_n_s, mosi_s})
    );

    cmdreg_fsm #(.DW(DW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .cs_n_s (cs_n_s),
        .mosi_s (mosi_s),
        .busy_i (busy),
        .rdat_i (rdat),
        .radr_o (radr),
        .we_o   (we),
        .wadr_o (wadr),
        .wdat_o (wdat),
        .done_o (done),
        .miso_o (miso)
    );

    cmdreg_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .wadr_i (wadr),
        .wdat_i (wdat),
        .radr_i (radr),
        .rdat_o (rdat)
    );

    cmdreg_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .busy_o (busy)
    );
endmodule

// File: tb/sim_cmdreg_slave.sv
`timescale 1ns/1ps
module sim_cmdreg_slave;
    localparam int NREG = 4;
    localparam int HOLD = 40;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, busy;

    int total = 0;
    int bad = 0;
    int busy_acc = 0;
    logic [15:0] model [NREG];

    always #2 clk = ~clk;

    cmdreg_slave #(.NUM_REGS(NREG), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_acc++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] op, input logic [7:0] adr, input logic [15:0] dat,
                        input int nbits, output logic [15:0] rd, output logic anyhi, output logic pre);
        logic [31:0] fr;
        fr = {op, adr, dat};
        rd = '0; anyhi = 1'b0; pre = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = fr[31-i];
            repeat (H) @(negedge clk);
            if (miso) anyhi = 1'b1;
            if (i >= 16) rd = {rd[14:0], miso};
            sck = 1'b1;
            repeat (H) @(negedge clk);
            if (i == 15) pre = miso;
            if (miso) anyhi = 1'b1;
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic settle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        busy_acc = 0;
    endtask

    task automatic rd_chk(input logic [7:0] adr, input logic [15:0] exp, input string req);
        logic [15:0] rd;
        logic hi, pre;
        settle();
        xfer(8'h03, adr, 16'h0, 32, rd, hi, pre);
        chk(rd == exp, req, {16'h0, rd}, {16'h0, exp});
        chk(pre == 1'b0, "R3 early miso", {31'h0, pre}, 32'h0);
    endtask

    task automatic wr(input logic [7:0] adr, input logic [15:0] dat);
        logic [15:0] rd;
        logic hi, pre;
        settle();
        xfer(8'h02, adr, dat, 32, rd, hi, pre);
        if (adr < NREG) model[adr] = dat;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic hi, pre;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
        chk(miso == 1'b0, "R1 miso", {31'h0, miso}, 32'h0);
        for (int a = 0; a < NREG; a++) rd_chk(8'(a), 16'h0, "R1 reg reset");

        // R2 R3 sweep of every bit position across registers
        for (int b = 0; b < 16; b++) begin
            logic [15:0] v;
            v = (16'h1 << b) ^ {4{4'(b)}};
            wr(8'(b % NREG), v);
            rd_chk(8'(b % NREG), v, "R2 R3 write/read");
        end
        for (int a = 0; a < NREG; a++) rd_chk(8'(a), model[a], "R4 neighbours intact");

        // R8 busy length after a write and a read
        settle();
        xfer(8'h02, 8'd1, 16'hA5C3, 32, rd, hi, pre);
        model[1] = 16'hA5C3;
        while (busy) @(negedge clk);
        chk(busy_acc == HOLD, "R8 busy after write", busy_acc, HOLD);
        settle();
        xfer(8'h03, 8'd1, 16'h0, 32, rd, hi, pre);
        while (busy) @(negedge clk);
        chk(busy_acc == HOLD, "R8 busy after read", busy_acc, HOLD);
        chk(rd == 16'hA5C3, "R3 read data", {16'h0, rd}, 32'hA5C3);

        // R4 out-of-range addresses
        wr(8'd4, 16'hDEAD);
        wr(8'hFF, 16'hBEEF);
        for (int a = 0; a < NREG; a++) rd_chk(8'(a), model[a], "R4 oor write");
        rd_chk(8'd4, 16'h0, "R4 oor read");
        rd_chk(8'h80, 16'h0, "R4 oor read");

        // R5 unknown opcodes
        settle();
        xfer(8'h05, 8'd2, 16'h7777, 32, rd, hi, pre);
        chk(hi == 1'b0, "R5 miso quiet", {31'h0, hi}, 32'h0);
        chk(busy_acc == 0, "R5 no busy", busy_acc, 0);
        settle();
        xfer(8'h82, 8'd2, 16'h7777, 32, rd, hi, pre);
        chk(hi == 1'b0, "R5 miso quiet", {31'h0, hi}, 32'h0);
        rd_chk(8'd2, model[2], "R5 no write");

        // R6 R7 abandoned frames
        settle();
        xfer(8'h02, 8'd2, 16'h1357, 31, rd, hi, pre);
        chk(busy_acc == 0, "R6 no busy", busy_acc, 0);
        rd_chk(8'd2, model[2], "R7 31-bit write");
        settle();
        xfer(8'h02, 8'd3, 16'h2468, 20, rd, hi, pre);
        rd_chk(8'd3, model[3], "R6 20-bit write");

        // R9 frame started while busy
        wr(8'd3, 16'h1234);
        chk(busy == 1'b1, "R9 busy at start", {31'h0, busy}, 32'h1);
        xfer(8'h02, 8'd3, 16'hBEEF, 32, rd, hi, pre);
        settle();
        xfer(8'h03, 8'd3, 16'h0, 32, rd, hi, pre);
        chk(rd == 16'h1234, "R9 ignored write", {16'h0, rd}, 32'h1234);
        wr(8'd3, 16'h1234);
        xfer(8'h03, 8'd3, 16'h0, 32, rd, hi, pre);
        chk(hi == 1'b0, "R9 miso quiet", {31'h0, hi}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule